// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds eight 32-bit general-purpose registers behind one write port and two read ports. Each port names a register and a part of it. A part is the whole word, the low half, the low byte or the second byte. All parts of one register are views onto the same 32-bit entry. A narrow write therefore merges into the stored word. A narrow read returns its field moved down to bit 0, with zeros above it.

Only the first four registers have the two byte views. The last four accept whole-word and low-half accesses only. The top half of a register has no part select of its own, so no port can reach it without also covering the low half. A byte access to one of the last four registers is refused: a write changes nothing, a read returns zero, and a one-cycle error pulse follows. Reads are combinational. Writes take effect at the rising clock edge.

All ports are plain, cycle-by-cycle control pins. Nothing flows through the block as a stream, so there is no valid/ready handshake and no back-pressure. A write happens on every edge where `wr_en` is high and the access is legal. A read is checked on every edge where its enable is high.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero and holds `err` low; after reset, every full read returns 0.
- R2: With part code 2'b00 a write stores all 32 bits of `wr_data` into register `wr_idx`, and a full read returns that word unchanged.
- R3: A narrow write changes only its field and keeps every other bit. Code 2'b01 writes bits [15:0] from `wr_data[15:0]`. Code 2'b10 writes bits [7:0] from `wr_data[7:0]`. Code 2'b11 writes bits [15:8], also from `wr_data[7:0]`. No code writes bits [31:16] without bits [15:0].
- R4: All parts of a register share one entry. Writing 1 through code 2'b11 and then 1 through code 2'b10 into a zeroed register makes both the 2'b01 read and the 2'b00 read return 257.
- R5: A narrow read returns its field zero-extended to 32 bits. Code 2'b01 returns bits [15:0] and code 2'b10 returns bits [7:0]. Code 2'b11 returns bits [15:8] placed at bits [7:0].
- R6: A write with code 2'b10 or 2'b11 to registers 4 to 7 is illegal and leaves that register unmodified.
- R7: An illegal access sets `err` high for exactly the one cycle after the edge that samples it. An illegal access is an enabled write, or an enabled read, with a byte code to registers 4 to 7. An illegal read returns 0 on its data port.
- R8: A read of the register being written in the same cycle returns the old value; the new value is visible after the write edge.
- R9: The two read ports are independent: each returns the view its own index and part select ask for, in the same cycle.

Ports table notes: `wr_part`, `rd0_part` and `rd1_part` take the part codes from R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register written |
| wr_part | input | 2 | Part select of the write |
| wr_data | input | 32 | Write data, with the field held in its low bits |
| rd0_en | input | 1 | Read port 0 enable (error checking; data is 0 when low) |
| rd0_idx | input | 3 | Read port 0 register |
| rd0_part | input | 2 | Read port 0 part select |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_idx | input | 3 | Read port 1 register |
| rd1_part | input | 2 | Read port 1 part select |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| err | output | 1 | One-cycle pulse after an illegal access |

## Verification
Each register is first filled with its own distinct word, so a decode that reaches the wrong entry shows up on readback. A word with a different value in every byte is then narrowed through each part code on both read ports. This tells a shifted or wrongly extended view apart from a correct one. A fixed word is then overwritten field by field, including the second-byte and low-half cases, which shows whether a merge leaks into neighbouring bits or into the top half. Byte accesses to the upper registers, and a read of a register in the same cycle it is written, separate refusal and old-value timing from ordinary writes.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PART_FULL = 2'b00,
    PART_HALF = 2'b01,
    PART_LOB  = 2'b10,
    PART_HIB  = 2'b11
  } part_e;

  function automatic logic is_byte_part(input logic [1:0] p);
    return (p == PART_LOB) || (p == PART_HIB);
  endfunction

endpackage

// File: rtl/alias_rf_check.sv
module alias_rf_check
  import alias_rf_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       part,
  output logic             legal
);

  localparam logic [IDX_W-1:0] BYTE_LIM = IDX_W'(NUM_BYTE_REGS);

  logic has_bytes;

  always_comb begin
    has_bytes = (idx < BYTE_LIM);
    legal     = !is_byte_part(part) || has_bytes;
  end

endmodule

// File: rtl/alias_rf_merge.sv
module alias_rf_merge
  import alias_rf_pkg::*;
#(
  parameter int W = DATA_W,
  localparam int HW = W / 2
) (
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] new_data,
  input  logic [1:0]   part,
  output logic [W-1:0] merged
);

  always_comb begin
    merged = old_word;
    case (part)
      PART_FULL: merged = new_data;
      PART_HALF: merged[HW-1:0] = new_data[HW-1:0];
      PART_LOB:  merged[BYTE_W-1:0] = new_data[BYTE_W-1:0];
      PART_HIB:  merged[2*BYTE_W-1:BYTE_W] = new_data[BYTE_W-1:0];
      default:   merged = old_word;
    endcase
  end

endmodule

// File: rtl/alias_rf_view.sv
module alias_rf_view
  import alias_rf_pkg::*;
#(
  parameter int W = DATA_W,
  localparam int HW = W / 2
) (
  input  logic [W-1:0] word,
  input  logic [1:0]   part,
  input  logic         pass,
  output logic [W-1:0] view
);

  always_comb begin
    view = '0;
    if (pass) begin
      case (part)
        PART_FULL: view = word;
        PART_HALF: view[HW-1:0] = word[HW-1:0];
        PART_LOB:  view[BYTE_W-1:0] = word[BYTE_W-1:0];
        PART_HIB:  view[BYTE_W-1:0] = word[2*BYTE_W-1:BYTE_W];
        default:   view = '0;
      endcase
    end
  end

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS),
  localparam int NUM_RD       = 2,
  localparam int HW           = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_part,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd0_en,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_part,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_en,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_part,
  output logic [DATA_W-1:0] rd1_data,
  output logic              err
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              wr_legal;
  logic [DATA_W-1:0] wr_merged;
  logic              err_q;

  logic              rd_en_a   [NUM_RD];
  logic [IDX_W-1:0]  rd_idx_a  [NUM_RD];
  logic [1:0]        rd_part_a [NUM_RD];
  logic [DATA_W-1:0] rd_data_a [NUM_RD];
  logic              rd_legal_a[NUM_RD];
  logic [NUM_RD-1:0] rd_bad;

  // write path: legality, merge of the field into the stored word
  alias_rf_check #(.NUM_REGS(NUM_REGS), .NUM_BYTE_REGS(NUM_BYTE_REGS)) u_wr_chk (
    .idx   (wr_idx),
    .part  (wr_part),
    .legal (wr_legal)
  );

  alias_rf_merge #(.W(DATA_W)) u_wr_merge (
    .old_word (regs_q[wr_idx]),
    .new_data (wr_data),
    .part     (wr_part),
    .merged   (wr_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en && wr_legal) begin
      regs_q[wr_idx] <= wr_merged;
    end
  end

  // read ports
  always_comb begin
    rd_en_a[0]   = rd0_en;
    rd_idx_a[0]  = rd0_idx;
    rd_part_a[0] = rd0_part;
    rd_en_a[1]   = rd1_en;
    rd_idx_a[1]  = rd1_idx;
    rd_part_a[1] = rd1_part;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    alias_rf_check #(.NUM_REGS(NUM_REGS), .NUM_BYTE_REGS(NUM_BYTE_REGS)) u_chk (
      .idx   (rd_idx_a[p]),
      .part  (rd_part_a[p]),
      .legal (rd_legal_a[p])
    );

    alias_rf_view #(.W(DATA_W)) u_view (
      .word (regs_q[rd_idx_a[p]]),
      .part (rd_part_a[p]),
      .pass (rd_en_a[p] && rd_legal_a[p]),
      .view (rd_data_a[p])
    );

    assign rd_bad[p] = rd_en_a[p] && !rd_legal_a[p];
  end

  assign rd0_data = rd_data_a[0];
  assign rd1_data = rd_data_a[1];

  // error pulse
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (wr_en && !wr_legal) || (|rd_bad);
  end

  assign err = err_q;

  // assertions
  a_r7_err_after_bad_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_byte_part(wr_part) && (wr_idx >= IDX_W'(NUM_BYTE_REGS))) |=> err);

  a_r6_bad_write_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_byte_part(wr_part) && (wr_idx >= IDX_W'(NUM_BYTE_REGS)))
      |=> regs_q[$past(wr_idx)] == $past(regs_q[wr_idx]));

  a_r3_half_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_part == PART_HALF)
      |=> regs_q[$past(wr_idx)][DATA_W-1:HW] == $past(regs_q[wr_idx][DATA_W-1:HW]));

  a_r3_hib_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_part == PART_HIB)
      |=> regs_q[$past(wr_idx)][BYTE_W-1:0] == $past(regs_q[wr_idx][BYTE_W-1:0]));

  a_r5_narrow_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd0_en && rd0_part != PART_FULL) |-> rd0_data[DATA_W-1:HW] == '0);

  a_r7_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd1_en && is_byte_part(rd1_part) && (rd1_idx >= IDX_W'(NUM_BYTE_REGS))) |-> rd1_data == '0);

endmodule

// File: tb/sim_alias_regfile.sv
module sim_alias_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_part = '0;
  logic [31:0] wr_data = '0;
  logic        rd0_en = 1'b0;
  logic [2:0]  rd0_idx = '0;
  logic [1:0]  rd0_part = '0;
  logic [31:0] rd0_data;
  logic        rd1_en = 1'b0;
  logic [2:0]  rd1_idx = '0;
  logic [1:0]  rd1_part = '0;
  logic [31:0] rd1_data;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alias_regfile u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part), .wr_data(wr_data),
    .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_part(rd0_part), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_idx(rd1_idx), .rd1_part(rd1_part), .rd1_data(rd1_data),
    .err(err)
  );

  logic [31:0] mdl [8];

  function automatic logic [31:0] view_of(input logic [31:0] w, input logic [1:0] p);
    case (p)
      2'b00:   return w;
      2'b01:   return {16'h0, w[15:0]};
      2'b10:   return {24'h0, w[7:0]};
      default: return {24'h0, w[15:8]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, commit on the following posedge, return at the next negedge
  task automatic wr(input int idx, input logic [1:0] p, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_part = p; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (!(p[1] && idx >= 4)) begin
      case (p)
        2'b00: mdl[idx] = d;
        2'b01: mdl[idx][15:0] = d[15:0];
        2'b10: mdl[idx][7:0] = d[7:0];
        default: mdl[idx][15:8] = d[7:0];
      endcase
    end
  endtask

  task automatic rd_both(input int i0, input logic [1:0] p0,
                         input int i1, input logic [1:0] p1,
                         output logic [31:0] d0, output logic [31:0] d1);
    rd0_en = 1'b1; rd0_idx = 3'(i0); rd0_part = p0;
    rd1_en = 1'b1; rd1_idx = 3'(i1); rd1_part = p1;
    #1;
    d0 = rd0_data; d1 = rd1_data;
    rd0_en = 1'b0; rd1_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    for (int i = 0; i < 8; i += 2) begin
      rd_both(i, 2'b00, i + 1, 2'b00, a, b);
      chk("R1 reset value", a, 32'h0);
      chk("R1 reset value", b, 32'h0);
    end
    chk("R1 err after reset", {31'h0, err}, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] a, b;
    for (int i = 0; i < 8; i++) wr(i, 2'b00, 32'h1111_1111 * (i + 1) ^ 32'h0F0F_0000);
    for (int i = 0; i < 8; i++) begin
      rd_both(i, 2'b00, 7 - i, 2'b00, a, b);
      chk("R2 full readback", a, mdl[i]);
      chk("R9 second port", b, mdl[7 - i]);
    end
  endtask

  task automatic t_merge;
    logic [31:0] a, b;
    wr(2, 2'b00, 32'hA5A5_A5A5);
    wr(2, 2'b01, 32'hFFFF_1234);
    rd_both(2, 2'b00, 2, 2'b00, a, b);
    chk("R3 half merge", a, 32'hA5A5_1234);
    wr(2, 2'b10, 32'hFFFF_FF77);
    rd_both(2, 2'b00, 2, 2'b00, a, b);
    chk("R3 low byte merge", a, 32'hA5A5_1277);
    wr(2, 2'b11, 32'h0000_0088);
    rd_both(2, 2'b00, 2, 2'b00, a, b);
    chk("R3 high byte merge", a, 32'hA5A5_8877);
    wr(5, 2'b00, 32'hCAFE_F00D);
    wr(5, 2'b01, 32'h0000_BEEF);
    rd_both(5, 2'b00, 2, 2'b00, a, b);
    chk("R3 half merge upper reg", a, 32'hCAFE_BEEF);
    chk("R3 neighbour untouched", b, 32'hA5A5_8877);
  endtask

  task automatic t_257;
    logic [31:0] a, b;
    wr(1, 2'b00, 32'h0);
    wr(1, 2'b11, 32'h1);
    wr(1, 2'b10, 32'h1);
    rd_both(1, 2'b01, 1, 2'b00, a, b);
    chk("R4 half view 257", a, 32'd257);
    chk("R4 full view 257", b, 32'd257);
  endtask

  task automatic t_views;
    logic [31:0] a, b;
    wr(3, 2'b00, 32'hDEAD_BEEF);
    rd_both(3, 2'b01, 3, 2'b10, a, b);
    chk("R5 half view", a, 32'h0000_BEEF);
    chk("R5 low byte view", b, 32'h0000_00EF);
    rd_both(3, 2'b11, 3, 2'b00, a, b);
    chk("R5 high byte view", a, 32'h0000_00BE);
    chk("R9 full on other port", b, 32'hDEAD_BEEF);
    rd_both(0, 2'b11, 7, 2'b01, a, b);
    chk("R9 port0 view", a, view_of(mdl[0], 2'b11));
    chk("R9 port1 view", b, view_of(mdl[7], 2'b01));
  endtask

  task automatic t_illegal;
    logic [31:0] a, b;
    wr(6, 2'b00, 32'h1357_9BDF);
    chk("R7 no err on legal write", {31'h0, err}, 32'h0);
    wr(6, 2'b10, 32'h0000_0000);
    chk("R7 err after bad write", {31'h0, err}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R7 err one cycle", {31'h0, err}, 32'h0);
    wr(6, 2'b11, 32'h0000_0000);
    rd_both(6, 2'b00, 6, 2'b01, a, b);
    chk("R6 bad write ignored", a, 32'h1357_9BDF);
    rd1_en = 1'b1; rd1_idx = 3'd4; rd1_part = 2'b10;
    #1;
    chk("R7 bad read data zero", rd1_data, 32'h0);
    @(posedge clk); @(negedge clk);
    rd1_en = 1'b0;
    chk("R7 err after bad read", {31'h0, err}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R7 err clears", {31'h0, err}, 32'h0);
  endtask

  task automatic t_rdw;
    logic [31:0] old;
    old = mdl[0];
    wr_en = 1'b1; wr_idx = 3'd0; wr_part = 2'b00; wr_data = 32'h0BAD_C0DE;
    rd0_en = 1'b1; rd0_idx = 3'd0; rd0_part = 2'b00;
    #1;
    chk("R8 old value during write", rd0_data, old);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    mdl[0] = 32'h0BAD_C0DE;
    chk("R8 new value after edge", rd0_data, 32'h0BAD_C0DE);
    rd0_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_merge();
    t_257();
    t_views();
    t_illegal();
    t_rdw();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule